// File: doc/BRIEF.md
# 16-bit Instruction Decoder

This block turns one 16-bit instruction word into the control signals that a simple load/store processor needs. The top nibble of the word chooses the operation. The next three nibbles are the destination and the two source register fields. Immediate moves carry an unsigned byte in the low eight bits. Jumps carry a 12-bit target in the low twelve bits. The decoder is purely combinational, so its outputs follow the instruction input within the same cycle. Fetch, program-counter update, memory access and execution are left to the blocks around it.

Opcode map: 0x0 through 0x7 are the eight ALU operations (ADD, SUB, AND, OR, XOR, NOT, SHL, SHR, in that order). 0x8 is MOV with an immediate. 0x9 is JMP, 0xA is JZ and 0xB is JNZ. 0xC is LD, 0xD is ST, 0xE is unassigned and 0xF is HLT. Three kinds of word are rejected as illegal: the unassigned opcode, an ST whose destination field is not zero, and an 0xF word with any low bit set. A rejected word raises `illegal_o` and drops every enable and control output.

Top module: `instr_decoder16`

## Requirements
- R1: The register outputs always carry fixed slices of the word, whatever the opcode: `rd_o` = bits 11:8, `rs_o` = bits 7:4, `rt_o` = bits 3:0.
- R2: For opcodes 0x0–0x7, `alu_en_o`=1 and `reg_wr_o`=1, and `alu_op_o` equals the low three opcode bits (ADD 000, SUB 001, AND 010, OR 011, XOR 100, NOT 101, SHL 110, SHR 111). No memory, jump, branch or halt output is set.
- R3: For opcode 0x8 (MOV), `reg_wr_o`=1 and `use_imm_o`=1, and `alu_en_o`=0. For every word, `imm_o` is bits 7:0 zero-extended to 16 bits.
- R4: For opcode 0xC (LD), `mem_rd_o`=1 and `reg_wr_o`=1, and `mem_wr_o`=0.
- R5: For opcode 0xD (ST) with bits 11:8 equal to zero, `mem_wr_o`=1, `reg_wr_o`=0 and `mem_rd_o`=0. An ST with a nonzero destination field is illegal.
- R6: For opcode 0x9 (JMP), `jump_o`=1. For every word, `target_o` is bits 11:0 zero-extended to 16 bits.
- R7: Opcode 0xA sets `br_z_o` only and opcode 0xB sets `br_nz_o` only. Neither writes a register or memory.
- R8: Only the exact word 0xF000 sets `halt_o`. Any other word with opcode 0xF is illegal.
- R9: Opcode 0xE, and every word rejected under R5 or R8, sets `illegal_o`=1 and forces `alu_en_o`, `use_imm_o`, `reg_wr_o`, `mem_rd_o`, `mem_wr_o`, `jump_o`, `br_z_o`, `br_nz_o`, `halt_o` to 0 and `alu_op_o` to 000.
- R10: At most one of `jump_o`, `br_z_o`, `br_nz_o`, `halt_o` is high. `mem_rd_o` and `mem_wr_o` are never high together. For every opcode outside 0x0–0x7, `alu_op_o` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| alu_op_o | output | 3 | ALU operation select |
| alu_en_o | output | 1 | Register-register ALU operation |
| rd_o | output | 4 | Destination register field |
| rs_o | output | 4 | First source register field |
| rt_o | output | 4 | Second source register field |
| imm_o | output | 16 | Zero-extended 8-bit immediate |
| target_o | output | 16 | Zero-extended 12-bit jump target |
| use_imm_o | output | 1 | Write-back value comes from the immediate |
| reg_wr_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| jump_o | output | 1 | Unconditional jump |
| br_z_o | output | 1 | Branch taken if zero flag set |
| br_nz_o | output | 1 | Branch taken if zero flag clear |
| halt_o | output | 1 | Halt the processor |
| illegal_o | output | 1 | Word is not a valid instruction |

## Verification
The bench targets the edges of the encoding:
- An ST with destination 0001 and an 0xF word with a single low bit set. A decoder that checked only the opcode would accept both, as a store and as a halt.
- The reserved opcode 0xE and immediates and targets with the top bit set. A decoder that sign-extended those fields would put ones in the upper bits.
- The walk over all eight ALU opcodes with varied register fields. This catches a swapped `alu_op_o` code or a field taken from the wrong nibble.
- The LD and ST pair. This catches a decoder that swapped the memory enables, or that let a store write a register.

// File: rtl/dec16_pkg.sv
package dec16_pkg;

    localparam int WORD_W   = 16;
    localparam int FIELD_W  = 4;
    localparam int IMM_W    = 8;
    localparam int ALUSEL_W = 3;

    typedef enum logic [FIELD_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_AND  = 4'h2,
        OP_OR   = 4'h3,
        OP_XOR  = 4'h4,
        OP_NOT  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_MOV  = 4'h8,
        OP_JMP  = 4'h9,
        OP_JZ   = 4'hA,
        OP_JNZ  = 4'hB,
        OP_LD   = 4'hC,
        OP_ST   = 4'hD,
        OP_RSVD = 4'hE,
        OP_HLT  = 4'hF
    } opcode_e;

    typedef struct packed {
        logic                alu_en;
        logic [ALUSEL_W-1:0] alu_op;
        logic                use_imm;
        logic                reg_wr;
        logic                mem_rd;
        logic                mem_wr;
        logic                jump;
        logic                br_z;
        logic                br_nz;
        logic                halt;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

    // Opcodes 0..7 share one class: ALU operation code is the opcode itself
    function automatic logic is_alu_class(opcode_e op);
        return op[FIELD_W-1] == 1'b0;
    endfunction

    function automatic ctrl_t class_ctrl(opcode_e op);
        ctrl_t c;
        c = CTRL_IDLE;
        if (is_alu_class(op)) begin
            c.alu_en = 1'b1;
            c.alu_op = op[ALUSEL_W-1:0];
            c.reg_wr = 1'b1;
        end else begin
            case (op)
                OP_MOV: begin
                    c.use_imm = 1'b1;
                    c.reg_wr  = 1'b1;
                end
                OP_JMP: c.jump  = 1'b1;
                OP_JZ:  c.br_z  = 1'b1;
                OP_JNZ: c.br_nz = 1'b1;
                OP_LD: begin
                    c.mem_rd = 1'b1;
                    c.reg_wr = 1'b1;
                end
                OP_ST:  c.mem_wr = 1'b1;
                OP_HLT: c.halt   = 1'b1;
                default: c = CTRL_IDLE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dec16_fields.sv
module dec16_fields #(
    parameter int WORD_W  = 16,
    parameter int FIELD_W = 4,
    parameter int IMM_W   = 8
) (
    input  logic [WORD_W-1:0]  word_i,
    output logic [FIELD_W-1:0] op_o,
    output logic [FIELD_W-1:0] rd_o,
    output logic [FIELD_W-1:0] rs_o,
    output logic [FIELD_W-1:0] rt_o,
    output logic [WORD_W-1:0]  imm_o,
    output logic [WORD_W-1:0]  target_o
);
    localparam int NFIELD = WORD_W / FIELD_W;
    localparam int TGT_W  = WORD_W - FIELD_W;

    logic [FIELD_W-1:0] nib [NFIELD];

    for (genvar i = 0; i < NFIELD; i++) begin : g_nib
        assign nib[i] = word_i[i*FIELD_W +: FIELD_W];
    end

    assign op_o     = nib[NFIELD-1];
    assign rd_o     = nib[NFIELD-2];
    assign rs_o     = nib[NFIELD-3];
    assign rt_o     = nib[NFIELD-4];
    assign imm_o    = {{(WORD_W-IMM_W){1'b0}}, word_i[IMM_W-1:0]};
    assign target_o = {{FIELD_W{1'b0}}, word_i[TGT_W-1:0]};

endmodule

// File: rtl/dec16_ctrl.sv
module dec16_ctrl
    import dec16_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] op_i,
    output ctrl_t              ctrl_o
);
    always_comb begin
        ctrl_o = class_ctrl(opcode_e'(op_i));
    end
endmodule

// File: rtl/dec16_guard.sv
module dec16_guard
    import dec16_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0]        op_i,
    input  logic [FIELD_W-1:0]        rd_i,
    input  logic [WORD_W-FIELD_W-1:0] body_i,
    input  ctrl_t                     raw_i,
    output ctrl_t                     ctrl_o,
    output logic                      illegal_o
);
    logic rsvd_op;
    logic bad_store;
    logic bad_halt;

    always_comb begin
        rsvd_op   = (opcode_e'(op_i) == OP_RSVD);
        bad_store = (opcode_e'(op_i) == OP_ST)  && (rd_i != '0);
        bad_halt  = (opcode_e'(op_i) == OP_HLT) && (body_i != '0);
        illegal_o = rsvd_op | bad_store | bad_halt;
        ctrl_o    = illegal_o ? CTRL_IDLE : raw_i;
    end
endmodule

// File: rtl/instr_decoder16.sv
module instr_decoder16
    import dec16_pkg::*;
(
    input  logic [15:0] instr_i,
    output logic [2:0]  alu_op_o,
    output logic        alu_en_o,
    output logic [3:0]  rd_o,
    output logic [3:0]  rs_o,
    output logic [3:0]  rt_o,
    output logic [15:0] imm_o,
    output logic [15:0] target_o,
    output logic        use_imm_o,
    output logic        reg_wr_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        jump_o,
    output logic        br_z_o,
    output logic        br_nz_o,
    output logic        halt_o,
    output logic        illegal_o
);
    localparam int BODY_W = WORD_W - FIELD_W;

    logic [FIELD_W-1:0] op;
    ctrl_t              raw_ctrl;
    ctrl_t              ctrl;

    dec16_fields #(
        .WORD_W (WORD_W),
        .FIELD_W(FIELD_W),
        .IMM_W  (IMM_W)
    ) u_fields (
        .word_i  (instr_i),
        .op_o    (op),
        .rd_o    (rd_o),
        .rs_o    (rs_o),
        .rt_o    (rt_o),
        .imm_o   (imm_o),
        .target_o(target_o)
    );

    dec16_ctrl #(
        .FIELD_W(FIELD_W)
    ) u_ctrl (
        .op_i  (op),
        .ctrl_o(raw_ctrl)
    );

    dec16_guard #(
        .WORD_W (WORD_W),
        .FIELD_W(FIELD_W)
    ) u_guard (
        .op_i     (op),
        .rd_i     (rd_o),
        .body_i   (instr_i[BODY_W-1:0]),
        .raw_i    (raw_ctrl),
        .ctrl_o   (ctrl),
        .illegal_o(illegal_o)
    );

    assign alu_en_o  = ctrl.alu_en;
    assign alu_op_o  = ctrl.alu_op;
    assign use_imm_o = ctrl.use_imm;
    assign reg_wr_o  = ctrl.reg_wr;
    assign mem_rd_o  = ctrl.mem_rd;
    assign mem_wr_o  = ctrl.mem_wr;
    assign jump_o    = ctrl.jump;
    assign br_z_o    = ctrl.br_z;
    assign br_nz_o   = ctrl.br_nz;
    assign halt_o    = ctrl.halt;

endmodule

// File: rtl/dec16_checker.sv
module dec16_checker (
    input logic [15:0] instr_i,
    input logic [2:0]  alu_op_o,
    input logic        alu_en_o,
    input logic [3:0]  rd_o,
    input logic [3:0]  rs_o,
    input logic [3:0]  rt_o,
    input logic [15:0] imm_o,
    input logic [15:0] target_o,
    input logic        use_imm_o,
    input logic        reg_wr_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic        jump_o,
    input logic        br_z_o,
    input logic        br_nz_o,
    input logic        halt_o,
    input logic        illegal_o
);
    always_comb begin
        assert_fields_R1: assert ({rd_o, rs_o, rt_o} == instr_i[11:0])
            else $error("register fields do not match word");
        assert_alu_sel_R2: assert (!alu_en_o || (alu_op_o == instr_i[14:12] && !instr_i[15]))
            else $error("ALU select disagrees with opcode");
        assert_imm_zext_R3: assert (imm_o[15:8] == 8'h00)
            else $error("immediate not zero-extended");
        assert_store_nowr_R5: assert (!mem_wr_o || !reg_wr_o)
            else $error("store writes a register");
        assert_tgt_zext_R6: assert (target_o[15:12] == 4'h0)
            else $error("target not zero-extended");
        assert_halt_word_R8: assert (!halt_o || instr_i == 16'hF000)
            else $error("halt on a non-halt word");
        assert_illegal_quiet_R9: assert (!illegal_o ||
            !(reg_wr_o | mem_rd_o | mem_wr_o | jump_o | br_z_o | br_nz_o | halt_o | alu_en_o | use_imm_o))
            else $error("illegal word left an enable set");
        assert_flow_onehot_R10: assert ($onehot0({jump_o, br_z_o, br_nz_o, halt_o}))
            else $error("more than one flow control set");
        assert_mem_excl_R10: assert (!(mem_rd_o && mem_wr_o))
            else $error("memory read and write together");
    end
endmodule

bind instr_decoder16 dec16_checker u_chk (.*);

// File: tb/sim_instr_decoder16.sv
module sim_instr_decoder16;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] instr_i = 16'h0000;
    logic [2:0]  alu_op_o;
    logic        alu_en_o;
    logic [3:0]  rd_o, rs_o, rt_o;
    logic [15:0] imm_o, target_o;
    logic use_imm_o, reg_wr_o, mem_rd_o, mem_wr_o;
    logic jump_o, br_z_o, br_nz_o, halt_o, illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    instr_decoder16 u0 (
        .instr_i  (instr_i),
        .alu_op_o (alu_op_o),
        .alu_en_o (alu_en_o),
        .rd_o     (rd_o),
        .rs_o     (rs_o),
        .rt_o     (rt_o),
        .imm_o    (imm_o),
        .target_o (target_o),
        .use_imm_o(use_imm_o),
        .reg_wr_o (reg_wr_o),
        .mem_rd_o (mem_rd_o),
        .mem_wr_o (mem_wr_o),
        .jump_o   (jump_o),
        .br_z_o   (br_z_o),
        .br_nz_o  (br_nz_o),
        .halt_o   (halt_o),
        .illegal_o(illegal_o)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s word=%h actual=%h expected=%h", req, what, instr_i, act, exp);
        end
    endtask

    // Flags packed as {alu_en,use_imm,reg_wr,mem_rd,mem_wr,jump,br_z,br_nz,halt,illegal}
    function automatic logic [15:0] flags();
        return {6'b0, alu_en_o, use_imm_o, reg_wr_o, mem_rd_o, mem_wr_o,
                jump_o, br_z_o, br_nz_o, halt_o, illegal_o};
    endfunction

    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        instr_i = w;
        #1;
    endtask

    task automatic t_initial();
        // word 0x0000 = ADD r0,r0,r0
        #1;
        check("R2", "init flags", flags(), 16'b1010000000);
        check("R1", "init fields", {4'h0, rd_o, rs_o, rt_o}, 16'h0000);
    endtask

    task automatic t_alu_ops();
        for (int k = 0; k < 8; k++) begin
            logic [15:0] w;
            w = {k[3:0], 4'(k + 1), 4'(7 - k), 4'(k ^ 4'hA)};
            apply(w);
            check("R2", "alu_op", {13'b0, alu_op_o}, {13'b0, k[2:0]});
            check("R2", "alu flags", flags(), 16'b1010000000);
            check("R1", "fields", {4'h0, rd_o, rs_o, rt_o}, {4'h0, w[11:0]});
        end
    endtask

    task automatic t_mov();
        apply(16'h8205);
        check("R3", "mov flags", flags(), 16'b0110000000);
        check("R3", "mov imm", imm_o, 16'h0005);
        check("R1", "mov rd", {12'b0, rd_o}, 16'h0002);
        check("R10", "mov alu_op", {13'b0, alu_op_o}, 16'h0000);
        apply(16'h83F7);
        check("R3", "mov imm high bit", imm_o, 16'h00F7);
    endtask

    task automatic t_load_store();
        apply(16'hC35A);
        check("R4", "ld flags", flags(), 16'b0011000000);
        apply(16'hD021);
        check("R5", "st flags", flags(), 16'b0000100000);
        check("R5", "st rs", {12'b0, rs_o}, 16'h0002);
        check("R5", "st rt", {12'b0, rt_o}, 16'h0001);
        apply(16'hD121);
        check("R5", "st rd!=0 illegal", flags(), 16'b0000000001);
    endtask

    task automatic t_flow();
        apply(16'h9ABC);
        check("R6", "jmp flags", flags(), 16'b0000010000);
        check("R6", "jmp target", target_o, 16'h0ABC);
        apply(16'h9FFF);
        check("R6", "jmp target max", target_o, 16'h0FFF);
        apply(16'hA010);
        check("R7", "jz flags", flags(), 16'b0000001000);
        apply(16'hB001);
        check("R7", "jnz flags", flags(), 16'b0000000100);
        check("R6", "jnz target", target_o, 16'h0001);
    endtask

    task automatic t_halt();
        apply(16'hF000);
        check("R8", "hlt flags", flags(), 16'b0000000010);
        apply(16'hF001);
        check("R8", "hlt low bit", flags(), 16'b0000000001);
        apply(16'hF800);
        check("R8", "hlt high body bit", flags(), 16'b0000000001);
    endtask

    task automatic t_illegal();
        apply(16'hE000);
        check("R9", "rsvd flags", flags(), 16'b0000000001);
        check("R9", "rsvd alu_op", {13'b0, alu_op_o}, 16'h0000);
        apply(16'hE7FF);
        check("R9", "rsvd alu_op all ones", {13'b0, alu_op_o}, 16'h0000);
        check("R1", "rsvd fields", {4'h0, rd_o, rs_o, rt_o}, 16'h07FF);
        // return to a legal word to show recovery
        apply(16'h5340);
        check("R2", "not after illegal", {13'b0, alu_op_o}, 16'h0005);
    endtask

    initial begin
        t_initial();
        t_alu_ops();
        t_mov();
        t_load_store();
        t_flow();
        t_halt();
        t_illegal();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule